// File: doc/BRIEF.md
# Nested Page Table Walker

This block turns a guest-physical address into a host-physical address by reading a second-stage page table held in memory. When a guest is entered, a pulse latches the walk settings: an enable flag, the nested table root address, the long-mode flag and the no-execute-enable flag. A later exit pulse drops the enable flag. A client then presents one request at a time. Each request carries a guest-physical address, an access kind (read, write or fetch) and a flag that tells whether the request is the final data access or a read of a guest page-table entry.

With the enable flag set, the walker reads one 8-byte entry per level through a single memory port. It checks each entry for presence and reserved bits, and it folds the permissions together level by level. A non-leaf entry whose accessed bit is clear is written back with that bit set. The walk ends in one of two ways. On success it returns the host address and the effective write and execute permissions. On a fault it returns a 64-bit exit-information word together with the faulting guest-physical address.

The controller has five states. S_IDLE waits for a request. S_FETCH issues an entry read and waits for the acknowledge. S_EVAL checks the entry that was read. S_ACCW writes the accessed bit back. S_RESP presents the result for one cycle.

The transitions are:
- S_IDLE to S_FETCH when a request arrives and walking is enabled.
- S_IDLE to S_RESP when a request arrives and walking is disabled.
- S_FETCH to S_EVAL on the acknowledge.
- S_EVAL to S_RESP on a fault or a leaf entry.
- S_EVAL to S_ACCW when an accessed-bit write-back is needed.
- S_EVAL to S_FETCH for the next level otherwise.
- S_ACCW to S_FETCH on the acknowledge.
- S_RESP to S_IDLE always.

Top module: `npt_walker`

## Requirements
- R1: When walking is disabled (the state after reset, or after an exit pulse), a request returns `hpa` equal to `req_gpa`, with `perm_w`=1, `perm_x`=1 and `fault`=0. No memory access is made.
- R2: With long mode set, the walk has four levels. The first entry address is the root with bits 11:0 cleared, plus gpa[47:39]×8. Each further entry address is the previous entry's frame bits [PA_BITS-1:12] plus the next 9-bit field (gpa[38:30], then gpa[29:21], then gpa[20:12]) times 8.
- R3: With long mode clear, the walk has three levels. The first entry address is the root with bits 4:0 cleared, plus gpa[31:30]×8. That first entry contributes no permissions, and it is never written back.
- R4: An entry whose bit 0 (present) is clear ends the walk with a not-present fault.
- R5: Any of the following ends the walk with a reserved fault:
  - bit 63 set while no-execute-enable is off, or bit 63 set in the three-level top entry;
  - bit 7 set in the four-level top entry;
  - any bit from 62 down to PA_BITS set;
  - any frame bit below the page size, other than bit 12, set in a large leaf.
- R6: The page size is set by where the leaf is found. Bit 7 set in a long-mode third-level entry gives a 1 GB page. Bit 7 set in a second-level entry gives a 2 MB page. A last-level entry gives a 4 KB page. `hpa` is the leaf frame with its page-offset bits cleared, plus the gpa offset within the page.
- R7: A non-leaf entry read with bit 5 (accessed) clear is written back to the same address with bit 5 set before the next read. A leaf entry is never written.
- R8: Across levels, bit 2 (user) and bit 1 (writable) are ANDed and bit 63 (no-execute) is ORed. On success, `perm_w` is the combined writable bit and `perm_x` is the inverse of the combined no-execute bit.
- R9: At the leaf, a protection fault is raised in three cases: the combined user bit is clear, a write meets a clear writable bit, or a fetch meets a set no-execute bit.
- R10: The fault word is built from these bits:
  - bit 2 is always set;
  - bit 3 is set for a reserved fault;
  - bit 0 is set for a reserved or a protection fault;
  - bit 1 is set for a write; bit 4 is set for a fetch;
  - bit 32 is set when `req_final`=1, and bit 33 when `req_final`=0.
- R11: On a fault, `fault_gpa` equals the request's guest-physical address and `hpa` is 0.
- R12: An entry pulse latches the enable flag, root, long-mode and no-execute-enable inputs. An exit pulse clears the enable flag, and it wins when both pulses arrive in the same cycle.
- R13: At most one memory operation is outstanding. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R14: `done` is a one-cycle pulse. `req_ready` is high only in S_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vm_enter | input | 1 | Guest-entry pulse; latches the settings below |
| vm_exit | input | 1 | Guest-exit pulse; clears the enable flag |
| enter_npt_en | input | 1 | Enable flag to latch |
| enter_base | input | 64 | Nested table root address to latch |
| enter_lma | input | 1 | Long-mode flag to latch |
| enter_nxe | input | 1 | No-execute-enable flag to latch |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_gpa | input | 64 | Guest-physical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_final | input | 1 | 1 = final data access, 0 = page-table access |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Operation complete |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Walk faulted |
| hpa | output | 64 | Host-physical address |
| perm_w | output | 1 | Effective write permission |
| perm_x | output | 1 | Effective execute permission |
| exit_info | output | 64 | Fault syndrome word |
| fault_gpa | output | 64 | Faulting guest-physical address |

## Verification
An entry pulse and an exit pulse can arrive in the same cycle. The bench drives both together with the enable input high, then checks that the next request passes straight through with no memory traffic. A reserved bit and a protection condition can also be present in the same leaf. The bench provokes that case with a no-execute leaf fetched while no-execute-enable is off, and it expects the reserved syndrome (bits 3, 0 and 2 set, bit 4 for the fetch) rather than a pure protection syndrome. Every result is checked against values computed from the requirements through a scoreboard queue.

// File: rtl/npt_pkg.sv
`timescale 1ns/1ps
package npt_pkg;
    typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
    typedef enum logic [1:0] {FLT_NONE, FLT_NOTP, FLT_RSVD, FLT_PROT} flt_e;
    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EVAL, S_ACCW, S_RESP} wstate_e;

    localparam int BIT_PRES = 0;
    localparam int BIT_WR   = 1;
    localparam int BIT_USR  = 2;
    localparam int BIT_ACC  = 5;
    localparam int BIT_PS   = 7;
    localparam int BIT_NX   = 63;
endpackage

// File: rtl/npt_entry_chk.sv
`timescale 1ns/1ps
module npt_entry_chk
    import npt_pkg::*;
#(
    parameter int PA_BITS = 52
) (
    input  logic [63:0] entry,
    input  logic [2:0]  level,
    input  logic        lma,
    input  logic        nxe,
    output logic        present,
    output logic        leaf,
    output logic        rsvd
);
    logic pae_top, ps, hi_bad, nx_bad, ps_bad, low_bad;
    logic unused_bits;

    assign unused_bits = ^{entry[6:1], entry[12:8], entry[PA_BITS-1:30]};
    assign pae_top = !lma && (level == 3'd3);
    assign ps      = entry[BIT_PS];
    assign present = entry[BIT_PRES];
    assign leaf    = (level == 3'd1) || (level == 3'd2 && ps) || (level == 3'd3 && lma && ps);
    assign hi_bad  = |entry[62:PA_BITS];
    assign nx_bad  = entry[BIT_NX] && (!nxe || pae_top);
    assign ps_bad  = ps && (level == 3'd4);

    always_comb begin
        low_bad = 1'b0;
        if (leaf && level == 3'd3) low_bad = |entry[29:13];
        else if (leaf && level == 3'd2) low_bad = |entry[20:13];
    end

    assign rsvd = hi_bad || nx_bad || ps_bad || low_bad;
endmodule

// File: rtl/npt_syndrome.sv
`timescale 1ns/1ps
module npt_syndrome
    import npt_pkg::*;
(
    input  flt_e        kind,
    input  acc_e        acc,
    input  logic        is_final,
    output logic [63:0] info
);
    always_comb begin
        info     = '0;
        info[3]  = (kind == FLT_RSVD);
        info[0]  = (kind == FLT_RSVD) || (kind == FLT_PROT);
        info[2]  = 1'b1;
        info[1]  = (acc == ACC_WRITE);
        info[4]  = (acc == ACC_FETCH);
        info[32] = is_final;
        info[33] = !is_final;
    end
endmodule

// File: rtl/npt_walker.sv
`timescale 1ns/1ps
module npt_walker
    import npt_pkg::*;
#(
    parameter int PA_BITS = 52
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vm_enter,
    input  logic        vm_exit,
    input  logic        enter_npt_en,
    input  logic [63:0] enter_base,
    input  logic        enter_lma,
    input  logic        enter_nxe,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_gpa,
    input  logic [1:0]  req_acc,
    input  logic        req_final,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [63:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [63:0] mem_rdata,
    output logic        done,
    output logic        fault,
    output logic [63:0] hpa,
    output logic        perm_w,
    output logic        perm_x,
    output logic [63:0] exit_info,
    output logic [63:0] fault_gpa
);
    localparam int ADDR_LO = 12;
    localparam int IDX_W   = 9;
    localparam logic [63:0] FRAME_MASK = ((64'd1 << PA_BITS) - 64'd1) & ~64'hFFF;

    // latched guest-entry settings
    logic        en_q, lma_q, nxe_q;
    logic [63:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; lma_q <= 1'b0; nxe_q <= 1'b0; base_q <= '0;
        end else if (vm_exit) begin
            en_q <= 1'b0;
        end else if (vm_enter) begin
            en_q <= enter_npt_en; base_q <= enter_base;
            lma_q <= enter_lma; nxe_q <= enter_nxe;
        end
    end

    wstate_e     state_q, state_d;
    logic [63:0] gpa_q, addr_q, ent_q;
    acc_e        acc_q;
    logic        fin_q, u_q, w_q, nx_q;
    logic [2:0]  lvl_q;
    logic        fault_q, pw_q, px_q;
    logic [63:0] hpa_q, info_q, fgpa_q;

    // entry evaluation
    logic        present, leaf, rsvd, pae_top, u_eff, w_eff, nx_eff, prot, need_acc;
    flt_e        kind;
    logic [63:0] syn, off_mask, leaf_hpa, first_addr, next_addr;
    logic [IDX_W-1:0] nidx;

    npt_entry_chk #(.PA_BITS(PA_BITS)) u_chk (
        .entry(ent_q), .level(lvl_q), .lma(lma_q), .nxe(nxe_q),
        .present(present), .leaf(leaf), .rsvd(rsvd)
    );

    npt_syndrome u_syn (.kind(kind), .acc(acc_q), .is_final(fin_q), .info(syn));

    assign pae_top = !lma_q && (lvl_q == 3'd3);
    assign u_eff   = pae_top ? 1'b1 : (u_q & ent_q[BIT_USR]);
    assign w_eff   = pae_top ? 1'b1 : (w_q & ent_q[BIT_WR]);
    assign nx_eff  = pae_top ? 1'b0 : (nx_q | (nxe_q & ent_q[BIT_NX]));
    assign prot    = !u_eff || (acc_q == ACC_FETCH && nx_eff) || (acc_q == ACC_WRITE && !w_eff);
    assign need_acc = !leaf && !pae_top && !ent_q[BIT_ACC];

    always_comb begin
        if (!present)          kind = FLT_NOTP;
        else if (rsvd)         kind = FLT_RSVD;
        else if (leaf && prot) kind = FLT_PROT;
        else                   kind = FLT_NONE;
    end

    always_comb begin
        unique case (lvl_q)
            3'd3:    off_mask = (64'd1 << (ADDR_LO + 2*IDX_W)) - 64'd1;
            3'd2:    off_mask = (64'd1 << (ADDR_LO + IDX_W)) - 64'd1;
            default: off_mask = (64'd1 << ADDR_LO) - 64'd1;
        endcase
        unique case (lvl_q)
            3'd4:    nidx = gpa_q[ADDR_LO + 2*IDX_W +: IDX_W];
            3'd3:    nidx = gpa_q[ADDR_LO + IDX_W +: IDX_W];
            default: nidx = gpa_q[ADDR_LO +: IDX_W];
        endcase
    end

    assign leaf_hpa   = (ent_q & FRAME_MASK & ~off_mask) | (gpa_q & off_mask);
    assign next_addr  = (ent_q & FRAME_MASK) + {52'd0, nidx, 3'b000};
    assign first_addr = lma_q
        ? (base_q & FRAME_MASK) + {52'd0, req_gpa[ADDR_LO + 3*IDX_W +: IDX_W], 3'b000}
        : (base_q & ~64'h1F) + {59'd0, req_gpa[31:30], 3'b000};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = en_q ? S_FETCH : S_RESP;
            S_FETCH: if (mem_ack) state_d = S_EVAL;
            S_EVAL:  if (kind != FLT_NONE || leaf) state_d = S_RESP;
                     else if (need_acc)            state_d = S_ACCW;
                     else                          state_d = S_FETCH;
            S_ACCW:  if (mem_ack) state_d = S_FETCH;
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // walk datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpa_q <= '0; addr_q <= '0; ent_q <= '0; acc_q <= ACC_READ; fin_q <= 1'b0;
            u_q <= 1'b1; w_q <= 1'b1; nx_q <= 1'b0; lvl_q <= 3'd0;
            fault_q <= 1'b0; pw_q <= 1'b0; px_q <= 1'b0;
            hpa_q <= '0; info_q <= '0; fgpa_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    gpa_q <= req_gpa; acc_q <= acc_e'(req_acc); fin_q <= req_final;
                    u_q <= 1'b1; w_q <= 1'b1; nx_q <= 1'b0;
                    if (en_q) begin
                        addr_q <= first_addr;
                        lvl_q  <= lma_q ? 3'd4 : 3'd3;
                    end else begin
                        fault_q <= 1'b0; hpa_q <= req_gpa; pw_q <= 1'b1; px_q <= 1'b1;
                        info_q <= '0; fgpa_q <= '0;
                    end
                end
                S_FETCH: if (mem_ack) ent_q <= mem_rdata;
                S_EVAL: begin
                    if (kind != FLT_NONE) begin
                        fault_q <= 1'b1; hpa_q <= '0; pw_q <= 1'b0; px_q <= 1'b0;
                        info_q <= syn; fgpa_q <= gpa_q;
                    end else if (leaf) begin
                        fault_q <= 1'b0; hpa_q <= leaf_hpa; pw_q <= w_eff; px_q <= !nx_eff;
                        info_q <= '0; fgpa_q <= '0;
                    end else begin
                        u_q <= u_eff; w_q <= w_eff; nx_q <= nx_eff;
                        if (!need_acc) begin
                            addr_q <= next_addr; lvl_q <= lvl_q - 3'd1;
                        end
                    end
                end
                S_ACCW: if (mem_ack) begin
                    addr_q <= next_addr; lvl_q <= lvl_q - 3'd1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        mem_req   = (state_q == S_FETCH) || (state_q == S_ACCW);
        mem_we    = (state_q == S_ACCW);
        mem_addr  = addr_q;
        mem_wdata = ent_q | (64'd1 << BIT_ACC);
        done      = (state_q == S_RESP);
    end

    assign fault     = fault_q;
    assign hpa       = hpa_q;
    assign perm_w    = pw_q;
    assign perm_x    = px_q;
    assign exit_info = info_q;
    assign fault_gpa = fgpa_q;

    // assertions
    assert_passthru_nomem_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid && !en_q) |=> (done && !mem_req && !fault));
    assert_wb_sets_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && mem_wdata[BIT_ACC]));
    assert_site_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> ($countones(exit_info[33:32]) == 1 && exit_info[2]));
    assert_rsvd_marks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && exit_info[3]) |-> exit_info[0]);
    assert_exit_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        vm_exit |=> !en_q);
    assert_hold_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ready_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done));
endmodule

// File: tb/npt_walker_tb.sv
`timescale 1ns/1ps
module npt_walker_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        vm_enter = 0, vm_exit = 0, enter_npt_en = 0, enter_lma = 0, enter_nxe = 0;
    logic [63:0] enter_base = '0;
    logic        req_valid = 0, req_ready, req_final = 0;
    logic [63:0] req_gpa = '0;
    logic [1:0]  req_acc = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, fault, perm_w, perm_x;
    logic [63:0] hpa, exit_info, fault_gpa;

    npt_walker u_dut (.*);

    typedef struct {
        logic flt; logic [63:0] hpa; logic pw; logic px; logic [63:0] info; logic [63:0] fgpa;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [63:0] mem [logic [63:0]];

    localparam logic [63:0] P = 64'h1, W = 64'h2, U = 64'h4, A = 64'h20, PS = 64'h80;
    localparam logic [63:0] NX = 64'h8000_0000_0000_0000;

    // memory model: acknowledge one request per idle negedge
    initial begin
        mem_ack = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 0;
            else if (mem_req) begin
                if (mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt++; end
                else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
                    rd_cnt++;
                end
                mem_ack = 1;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++; $display("FAIL unexpected done: actual done=1 expected none");
                end else begin
                    exp_t e; string t;
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    if (fault !== e.flt || hpa !== e.hpa || perm_w !== e.pw || perm_x !== e.px ||
                        exit_info !== e.info || fault_gpa !== e.fgpa) begin
                        fails++;
                        $display("FAIL %s: actual flt=%0b hpa=%h w=%0b x=%0b info=%h fgpa=%h expected flt=%0b hpa=%h w=%0b x=%0b info=%h fgpa=%h",
                            t, fault, hpa, perm_w, perm_x, exit_info, fault_gpa,
                            e.flt, e.hpa, e.pw, e.px, e.info, e.fgpa);
                    end
                end
            end
        end
    end

    task automatic check(input string t, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++; $display("FAIL %s: actual %h expected %h", t, act, expv);
        end
    endtask

    task automatic enter(input logic en, input logic [63:0] base, input logic lma,
                         input logic nxe, input logic also_exit);
        @(negedge clk);
        vm_enter = 1; vm_exit = also_exit; enter_npt_en = en;
        enter_base = base; enter_lma = lma; enter_nxe = nxe;
        @(negedge clk);
        vm_enter = 0; vm_exit = 0;
    endtask

    task automatic leave();
        @(negedge clk); vm_exit = 1;
        @(negedge clk); vm_exit = 0;
    endtask

    task automatic walk(input string t, input logic [63:0] gpa, input logic [1:0] acc,
                        input logic fin, input logic eflt, input logic [63:0] ehpa,
                        input logic epw, input logic epx, input logic [63:0] einfo);
        exp_t e;
        e.flt = eflt; e.hpa = ehpa; e.pw = epw; e.px = epx; e.info = einfo;
        e.fgpa = eflt ? gpa : 64'd0;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_gpa = gpa; req_acc = acc; req_final = fin;
        @(negedge clk);
        req_valid = 0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] ga(input int l4, input int l3, input int l2,
                                       input int l1, input logic [63:0] off);
        return (64'(l4) << 39) | (64'(l3) << 30) | (64'(l2) << 21) | (64'(l1) << 12) | off;
    endfunction

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int r0, w0;
        // long-mode tables rooted at 0x1000
        mem[64'h1008] = 64'h2000 | P | W | U | A;
        mem[64'h1010] = 64'h2000 | P | W | U | A | PS;
        mem[64'h2010] = 64'h3000 | P | W | U;
        mem[64'h2030] = 64'h4000_0000 | P | U | PS | A;
        mem[64'h3018] = 64'h4000 | P | W | U | A;
        mem[64'h3028] = 64'h60_0000 | P | W | U | PS | A;
        mem[64'h3030] = 64'h60_0000 | 64'h2000 | P | W | U | PS | A;
        mem[64'h4020] = 64'hABCD_E000 | P | W | U;
        mem[64'h4038] = 64'h5000 | P | W | U | NX;
        mem[64'h4048] = 64'h6000 | P | W;
        // three-level tables rooted at 0x8000
        mem[64'h8010] = 64'h9000 | P;
        mem[64'h9008] = 64'hA000 | P | W | U | A;
        mem[64'hA018] = 64'hB000 | P | W | U;

        repeat (3) @(negedge clk);
        // R14 reset state
        check("R14 reset ready", {63'd0, req_ready}, 64'd1);
        check("R14 reset done", {63'd0, done}, 64'd0);
        check("R13 reset mem_req", {63'd0, mem_req}, 64'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1/R12: disabled after reset -> pass-through
        r0 = rd_cnt; w0 = wr_cnt;
        walk("R1 reset pass", 64'h1234_5678, 2'd0, 1, 0, 64'h1234_5678, 1, 1, 0);
        check("R1 no mem", 64'(rd_cnt + wr_cnt), 64'(r0 + w0));

        enter(1, 64'h1000, 1, 1, 0);
        // R2/R6/R7/R8: 4 KB walk, one accessed write-back
        r0 = rd_cnt; w0 = wr_cnt;
        walk("R2 R6 4K read", ga(1, 2, 3, 4, 12'h567), 2'd0, 1, 0, 64'hABCD_E567, 1, 1, 0);
        check("R2 reads", 64'(rd_cnt - r0), 64'd4);
        check("R7 writes", 64'(wr_cnt - w0), 64'd1);
        check("R7 accessed set", mem[64'h2010], 64'h3027);
        check("R7 leaf untouched", mem[64'h4020], 64'hABCD_E007);
        // R6 2 MB
        w0 = wr_cnt;
        walk("R6 2M", ga(1, 2, 5, 0, 21'h12345), 2'd2, 1, 0, 64'h61_2345, 1, 1, 0);
        check("R7 no write when set", 64'(wr_cnt - w0), 64'd0);
        // R6/R8 1 GB read-only
        walk("R6 R8 1G read", ga(1, 6, 0, 0, 30'h123_4567), 2'd0, 1, 0, 64'h4123_4567, 0, 1, 0);
        walk("R9 R10 1G write", ga(1, 6, 0, 0, 30'h123_4567), 2'd1, 1, 1, 0, 0, 0, 64'h1_0000_0007);
        // R8/R9 no-execute
        walk("R8 NX read", ga(1, 2, 3, 7, 12'h0F0), 2'd0, 1, 0, 64'h50F0, 1, 0, 0);
        walk("R9 NX fetch", ga(1, 2, 3, 7, 12'h0F0), 2'd2, 1, 1, 0, 0, 0, 64'h1_0000_0015);
        walk("R9 no user", ga(1, 2, 3, 9, 12'h0), 2'd0, 1, 1, 0, 0, 0, 64'h1_0000_0005);
        // R4/R10/R11 not present
        walk("R4 notp table", ga(1, 2, 3, 8, 12'h10), 2'd0, 0, 1, 0, 0, 0, 64'h2_0000_0004);
        walk("R4 notp write", ga(1, 2, 3, 8, 12'h10), 2'd1, 1, 1, 0, 0, 0, 64'h1_0000_0006);
        // R5 reserved
        walk("R5 top PS", ga(2, 0, 0, 0, 12'h0), 2'd0, 0, 1, 0, 0, 0, 64'h2_0000_000D);
        walk("R5 large low bits", ga(1, 2, 6, 0, 12'h0), 2'd0, 1, 1, 0, 0, 0, 64'h1_0000_000D);
        enter(1, 64'h1000, 1, 0, 0);
        walk("R5 NX without NXE", ga(1, 2, 3, 7, 12'h0), 2'd0, 1, 1, 0, 0, 0, 64'h1_0000_000D);
        walk("R5 NX fetch without NXE", ga(1, 2, 3, 7, 12'h0), 2'd2, 1, 1, 0, 0, 0, 64'h1_0000_001D);
        // R3 three-level walk
        enter(1, 64'h8010, 0, 1, 0);
        r0 = rd_cnt; w0 = wr_cnt;
        walk("R3 three-level", (64'd2 << 30) | (64'd1 << 21) | (64'd3 << 12) | 64'hAB,
             2'd1, 1, 0, 64'hB0AB, 1, 1, 0);
        check("R3 reads", 64'(rd_cnt - r0), 64'd3);
        check("R3 no writes", 64'(wr_cnt - w0), 64'd0);
        // R12 exit clears enable
        leave();
        r0 = rd_cnt;
        walk("R12 after exit", 64'hFEED_0123, 2'd1, 1, 0, 64'hFEED_0123, 1, 1, 0);
        check("R1 no reads after exit", 64'(rd_cnt), 64'(r0));
        // R12 enter and exit in the same cycle: exit wins
        enter(1, 64'h1000, 1, 1, 1);
        r0 = rd_cnt;
        walk("R12 exit wins", 64'hDEAD_B000, 2'd2, 1, 0, 64'hDEAD_B000, 1, 1, 0);
        check("R12 no reads", 64'(rd_cnt), 64'(r0));

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule